// File: doc/BRIEF.md
# Streaming Horizontal Gradient Filter

This block turns a stream of unsigned pixels, delivered row by row, into a stream of signed horizontal gradients. For every pixel it reports the pixel to its right minus the pixel to its left on the same row. At the two ends of a row, the missing neighbour is replaced by the edge pixel itself. Input and output use valid, last and data with no ready. The block takes a pixel on every cycle in which valid is high. The output is one bit wider than the input, so every difference fits.

A column's result needs the pixel that follows it, so the result for column x leaves the block only once pixel x+1 has been taken. The final column of a row has no following pixel. Its result is held in a pending register and sent on the cycle after the last-marked beat. If rows arrive back to back, that cycle is also when the first pixel of the next row arrives. Only the two most recent pixels of the current row are stored.

Top module: `rowgrad_filter`

## Requirements
- R1: For column x of a row of width W, the output data equals in[min(x+1,W-1)] - in[max(x-1,0)]. The subtraction is signed and DATA_W+1 bits wide, with the input taken as unsigned.
- R2: The last column of a row of width W≥2 yields in[W-1] - in[W-2].
- R3: Column 0 of a row of width W≥2 yields in[1] - in[0].
- R4: A row of a single pixel (last high on the first beat) yields exactly one output, with value 0 and out_last high.
- R5: out_last is high on exactly one output per row: the output of the final column. It is never high while out_valid is low.
- R6: Every row produces as many outputs as it had inputs, in row-major order. Input beats on consecutive cycles, including across row boundaries, are all accepted.
- R7: A column x < W-1 is presented on the outputs in the cycle after the one in which pixel x+1 was taken. A column-0 beat on its own produces no output in the next cycle.
- R8: The final-column result is presented in the second cycle after the last-marked beat. A synchronous active-high reset sampled in between discards it.
- R9: Reset clears all state, so out_valid and out_last are low after reset. A partial row and a pending result are dropped, and the first valid beat after reset is column 0 of a new row.
- R10: A cycle with in_valid low changes no stored pixel. Idle cycles inside or between rows leave all results unchanged, and out_valid stays low in any cycle that follows an idle input cycle in which no pending result is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present this cycle |
| in_last | input | 1 | Input pixel is the final one of its row |
| in_data | input | DATA_W | Unsigned input pixel |
| out_valid | output | 1 | Output gradient present this cycle (registered) |
| out_last | output | 1 | Output is the final column of its row |
| out_data | output | DATA_W+1 | Signed gradient |

## Verification
Two things can happen in the same cycle. The pending final-column result of one row is sent out while the first pixel of the next row arrives. The bench provokes this by sending rows with no idle cycle between them, including single-pixel rows, so that every row boundary hits this cycle. It judges the result by the order, values and last flags of the output stream against a model computed from the equation. An assertion also checks that a pending send and a mid-row send are never requested in the same cycle. A reset placed exactly between a last beat and its pending send checks that the held result is dropped.

// File: rtl/rowgrad_pkg.sv
package rowgrad_pkg;

  // Whether a row has been started and not yet closed by a last beat.
  typedef enum logic {
    ROW_IDLE = 1'b0,
    ROW_OPEN = 1'b1
  } row_state_e;

  // Source selected for the output register in a cycle.
  typedef enum logic [1:0] {
    EMIT_NONE = 2'd0,
    EMIT_MID  = 2'd1,
    EMIT_TAIL = 2'd2
  } emit_kind_e;

endpackage

// File: rtl/rowgrad_track.sv
module rowgrad_track
  import rowgrad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_last,
  output logic row_open,
  output logic start_evt,
  output logic mid_evt,
  output logic close_evt
);

  row_state_e state_q;
  row_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (in_valid) begin
      state_d = in_last ? ROW_IDLE : ROW_OPEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ROW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign row_open  = (state_q == ROW_OPEN);
  // First pixel of a row: nothing can be emitted yet.
  assign start_evt = in_valid & ~row_open;
  // Pixel x>=1: the result for column x-1 is now complete.
  assign mid_evt   = in_valid & row_open;
  // Final pixel of a row: the tail result must be held.
  assign close_evt = in_valid & in_last;

endmodule

// File: rtl/rowgrad_taps.sv
module rowgrad_taps #(
  parameter int DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_evt,
  input  logic                     mid_evt,
  input  logic                     row_open,
  input  logic [DATA_W-1:0]        pix,
  output logic signed [DATA_W:0]   mid_diff,
  output logic signed [DATA_W:0]   tail_diff
);

  localparam int OUT_W = DATA_W + 1;

  // Right minus left, with both pixels zero-extended before the subtraction.
  function automatic logic signed [OUT_W-1:0] grad_sub(
    input logic [DATA_W-1:0] right_px,
    input logic [DATA_W-1:0] left_px
  );
    grad_sub = $signed({1'b0, right_px}) - $signed({1'b0, left_px});
  endfunction

  // prev_q: most recent pixel of the row (column x-1 when pixel x arrives).
  // left_q: left neighbour of column x-1, already clamped at column 0.
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] left_q;
  logic [DATA_W-1:0] tail_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      left_q <= '0;
    end else if (start_evt) begin
      prev_q <= pix;
      left_q <= pix;
    end else if (mid_evt) begin
      left_q <= prev_q;
      prev_q <= pix;
    end
  end

  // A single-pixel row clamps both neighbours to the pixel itself.
  assign tail_left = row_open ? prev_q : pix;
  assign mid_diff  = grad_sub(pix, left_q);
  assign tail_diff = grad_sub(pix, tail_left);

endmodule

// File: rtl/rowgrad_emit.sv
module rowgrad_emit
  import rowgrad_pkg::*;
#(
  parameter int OUT_W = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mid_evt,
  input  logic                    close_evt,
  input  logic signed [OUT_W-1:0] mid_diff,
  input  logic signed [OUT_W-1:0] tail_diff,
  output logic                    flush_evt,
  output logic                    out_valid,
  output logic                    out_last,
  output logic signed [OUT_W-1:0] out_data
);

  logic                    pend_valid_q;
  logic signed [OUT_W-1:0] pend_data_q;
  emit_kind_e              kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid_q <= 1'b0;
      pend_data_q  <= '0;
    end else begin
      pend_valid_q <= close_evt;
      if (close_evt) begin
        pend_data_q <= tail_diff;
      end
    end
  end

  assign flush_evt = pend_valid_q;

  // A flush cycle follows a last beat, so the row is idle and mid_evt is low;
  // the tail takes priority all the same.
  always_comb begin
    if (flush_evt) begin
      kind = EMIT_TAIL;
    end else if (mid_evt) begin
      kind = EMIT_MID;
    end else begin
      kind = EMIT_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      case (kind)
        EMIT_TAIL: begin
          out_valid <= 1'b1;
          out_last  <= 1'b1;
          out_data  <= pend_data_q;
        end
        EMIT_MID: begin
          out_valid <= 1'b1;
          out_last  <= 1'b0;
          out_data  <= mid_diff;
        end
        default: begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/rowgrad_filter.sv
module rowgrad_filter #(
  parameter int DATA_W = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   out_valid,
  output logic                   out_last,
  output logic signed [DATA_W:0] out_data
);

  localparam int OUT_W = DATA_W + 1;

  logic                    row_open;
  logic                    start_evt;
  logic                    mid_evt;
  logic                    close_evt;
  logic                    flush_evt;
  logic signed [OUT_W-1:0] mid_diff;
  logic signed [OUT_W-1:0] tail_diff;

  rowgrad_track u_track (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .row_open  (row_open),
    .start_evt (start_evt),
    .mid_evt   (mid_evt),
    .close_evt (close_evt)
  );

  rowgrad_taps #(.DATA_W(DATA_W)) u_taps (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .mid_evt   (mid_evt),
    .row_open  (row_open),
    .pix       (in_data),
    .mid_diff  (mid_diff),
    .tail_diff (tail_diff)
  );

  rowgrad_emit #(.OUT_W(OUT_W)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .mid_evt   (mid_evt),
    .close_evt (close_evt),
    .mid_diff  (mid_diff),
    .tail_diff (tail_diff),
    .flush_evt (flush_evt),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data)
  );

endmodule

// File: rtl/rowgrad_filter_chk.sv
module rowgrad_filter_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_last,
  input logic row_open,
  input logic mid_evt,
  input logic flush_evt,
  input logic out_valid,
  input logic out_last
);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last));

  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R6
  emit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flush_evt && mid_evt));

  // R8
  flush_emits_last_chk: assert property (@(posedge clk) disable iff (rst)
    flush_evt |=> (out_valid && out_last));

  // R7
  mid_emits_chk: assert property (@(posedge clk) disable iff (rst)
    mid_evt |=> (out_valid && !out_last));

  // R4
  single_close_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && !row_open) |=> flush_evt);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flush_evt) |=> !out_valid);

endmodule

bind rowgrad_filter rowgrad_filter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .row_open  (row_open),
  .mid_evt   (mid_evt),
  .flush_evt (flush_evt),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/sim_rowgrad_filter.sv
`timescale 1ns/1ps
module sim_rowgrad_filter;

  localparam int DW = 8;
  localparam int NT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_last;
  logic signed [DW:0] out_data;

  int ntot = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  string cur_tag = "R1";
  logic [DW+1:0] exp_q[$];

  // Each stimulus entry: {last, pixel}. Rows: 3 px, 1 px, 2 px, 4 px, back to back.
  localparam logic [DW:0] STIM_TAB [NT] = '{
    {1'b0, 8'd10}, {1'b0, 8'd20}, {1'b1, 8'd50},
    {1'b1, 8'd7},
    {1'b0, 8'd5},  {1'b1, 8'd200},
    {1'b0, 8'd255}, {1'b0, 8'd0}, {1'b0, 8'd0}, {1'b1, 8'd255}
  };
  // Each expected entry: {last, 9-bit two's complement gradient}.
  localparam logic [DW+1:0] EXP_TAB [NT] = '{
    {1'b0, 9'd10}, {1'b0, 9'd40}, {1'b1, 9'd30},
    {1'b1, 9'd0},
    {1'b0, 9'd195}, {1'b1, 9'd195},
    {1'b0, 9'h101}, {1'b0, 9'h101}, {1'b0, 9'd255}, {1'b1, 9'd255}
  };

  always #10 clk = ~clk;

  rowgrad_filter #(.DATA_W(DW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send_beat(input logic lst, input logic [DW-1:0] px);
    @(negedge clk);
    in_valid = 1'b1;
    in_last  = lst;
    in_data  = px;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  // Stream monitor: compares each output beat with the model queue.
  always @(negedge clk) begin
    if (mon_en && !rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected beat data", int'(out_data), 0);
      end else begin
        logic [DW+1:0] e;
        e = exp_q.pop_front();
        chk(out_data == $signed(e[DW:0]), cur_tag, "data",
            int'(out_data), int'($signed(e[DW:0])));
        chk(out_last == e[DW+1], cur_tag, "last",
            int'(out_last), int'(e[DW+1]));
      end
    end
  end

  // Independent model of one row: clamped right minus left neighbour.
  task automatic send_row(input int w, input int gap_max);
    int px[16];
    int l, r;
    for (int x = 0; x < w; x++) px[x] = int'($urandom_range(0, 255));
    for (int x = 0; x < w; x++) begin
      r = (x + 1 > w - 1) ? px[w-1] : px[x+1];
      l = (x - 1 < 0) ? px[0] : px[x-1];
      exp_q.push_back({(x == w - 1), 9'(r - l)});
    end
    for (int x = 0; x < w; x++) begin
      send_beat(x == w - 1, px[x][DW-1:0]);
      if (gap_max > 0) idle(int'($urandom_range(0, gap_max)));
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntot++;
      nfail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R9", "out_last in reset", int'(out_last), 0);
    rst = 1'b0;
    idle(2);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);

    // Table walk: R1 R2 R3 R4 R5, rows back to back so flush meets a new row (R6)
    cur_tag = "R1_R2_R3_R4_R5_R6";
    mon_en = 1'b1;
    for (int i = 0; i < NT; i++) exp_q.push_back(EXP_TAB[i]);
    for (int i = 0; i < NT; i++) send_beat(STIM_TAB[i][DW], STIM_TAB[i][DW-1:0]);
    idle(4);
    chk(exp_q.size() == 0, "R6", "table outputs left", exp_q.size(), 0);

    // R7 R8: cycle-exact latency on row 1,2,4
    mon_en = 1'b0;
    send_beat(1'b0, 8'd1);
    send_beat(1'b0, 8'd2);
    chk(out_valid == 1'b0, "R7", "valid after column-0 beat", int'(out_valid), 0);
    send_beat(1'b1, 8'd4);
    chk(out_valid && !out_last && out_data == 1, "R7", "col0 data", int'(out_data), 1);
    idle(1);
    chk(out_valid && !out_last && out_data == 3, "R7", "col1 data", int'(out_data), 3);
    idle(1);
    chk(out_valid && out_last && out_data == 2, "R8", "tail data", int'(out_data), 2);
    idle(1);
    chk(out_valid == 1'b0, "R10", "valid after idle", int'(out_valid), 0);

    // R8 R9: reset between last beat and pending send
    send_beat(1'b1, 8'd77);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "pending dropped by reset", int'(out_valid), 0);
    rst = 1'b0;

    // R9: partial row dropped, next beat is column 0
    mon_en = 1'b1;
    cur_tag = "R9";
    send_beat(1'b0, 8'd120);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.push_back({1'b0, 9'h1FA});
    exp_q.push_back({1'b1, 9'h1FA});
    send_beat(1'b0, 8'd9);
    send_beat(1'b1, 8'd3);
    idle(4);
    chk(exp_q.size() == 0, "R9", "outputs left after reset", exp_q.size(), 0);

    // Random images, continuous then with gaps: R1 R5 R6 R10
    cur_tag = "R1_R5_R6";
    foreach (STIM_TAB[k]) begin end
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) cur_tag = "R10";
      send_row(1, pass * 2);
      for (int y = 0; y < 4; y++) send_row(1, pass * 2);
      send_row(5, pass * 2);
      for (int y = 0; y < 3; y++) send_row(2, pass * 2);
      for (int y = 0; y < 6; y++) send_row(7, pass * 2);
      for (int y = 0; y < 4; y++) send_row(16, pass * 2);
      idle(5);
      chk(exp_q.size() == 0, "R6", "random outputs left", exp_q.size(), 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule